// File: doc/BRIEF.md
# Chained DMA Channel Scheduler

This block decides which of several DMA channels owns a single shared transfer engine. Each channel has a hardware trigger input, an auto-reload flag and a link field that names the channel to kick when its own frame completes. Triggers and link kicks are held as sticky pending bits. Whenever the engine is idle, the scheduler grants the lowest-numbered armed pending channel, so channel 0 always wins. The engine itself is outside the block and is represented by a start pulse going out and a done pulse coming back, one frame per grant.

Because lower numbers win, a chain only runs through completely when it steps from higher channel numbers to lower ones. If the chain steps upward and the trigger keeps arriving at the head channel, the head keeps preempting the rest and runs over and over. A channel without auto-reload disarms itself after its frame and ignores further requests until reset. A chain-done pulse marks the completion of any frame whose link field is empty.

Top module: `dma_chain_sched`

## Requirements
- R1: During and right after reset, `start_o`, `busy_o` and `chain_done_o` are 0, and all channels are armed.
- R2: When the engine is idle and one or more armed channels are pending, `start_o` is 1 in that cycle and `start_ch_o` is the lowest pending channel number.
- R3: While `busy_o` is 1, `start_o` stays 0 and `active_ch_o` holds its value. A running frame is never interrupted, and arbitration waits for `done_i`.
- R4: A trigger on an armed channel sets a sticky pending bit, so the start pulse appears one cycle later if the engine is idle. A grant clears that channel's pending bit. A trigger that arrives in the same cycle as the grant keeps the bit set.
- R5: Link field encoding: for channel c, bits [c*2 +: 2] of `cfg_link_i` hold the link. 0 means no successor, and a value k means channel k-1 becomes pending when `done_i` ends c's frame.
- R6: `chain_done_o` pulses in the same cycle as an accepted `done_i` when the active channel's link field is 0.
- R7: `done_i` while the engine is idle is ignored: there is no chain-done pulse, `busy_o` stays low and no start follows.
- R8: If `cfg_autoinit_i[c]` is 0 when c's frame ends, channel c disarms, and its triggers and link kicks are ignored until reset. Other channels are unaffected. With the flag set to 1, c stays armed.
- R9: With the chain 0→1→2 and the trigger held on channel 0, channel 0 is granted every time. With the chain 2→1→0 and the trigger held on channel 2, the grants repeat in the order 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_trig_i | input | NCH | Per-channel hardware trigger |
| cfg_link_i | input | NCH*LINK_W | Per-channel link field, channel c at [c*LINK_W +: LINK_W] |
| cfg_autoinit_i | input | NCH | Per-channel auto-reload flag |
| done_i | input | 1 | Engine reports end of the current frame |
| start_o | output | 1 | Grant pulse to the engine |
| start_ch_o | output | CH_W | Channel granted with `start_o` |
| busy_o | output | 1 | Engine owned by a channel |
| active_ch_o | output | CH_W | Channel owning the engine |
| chain_done_o | output | 1 | A frame with an empty link field ended |

## Verification
The hardest situation to reach is a new trigger competing with a link kick at the same idle cycle. This is where priority alone decides whether a chain finishes or starves. The bench holds a trigger high continuously while a model engine answers each grant after a fixed frame length. That produces the collision on every frame boundary, and the bench then compares the grant order for the upward and downward chains. A trigger that lands in the grant cycle itself comes from the same held stimulus.

// File: rtl/dmasch_pkg.sv
package dmasch_pkg;
  localparam int MAX_CH = 16;
  typedef logic [MAX_CH-1:0] chvec_t;

  // Link value k (k>0) selects channel k-1; 0 selects nothing.
  function automatic chvec_t link_target(input int unsigned link);
    chvec_t v;
    v = '0;
    for (int unsigned i = 0; i < MAX_CH; i++) v[i] = (link == i + 1);
    return v;
  endfunction

  // Isolate the lowest set bit (lowest number = highest priority).
  function automatic chvec_t lowest_onehot(input chvec_t v);
    return v & (~v + chvec_t'(1));
  endfunction
endpackage

// File: rtl/dmasch_req_bank.sv
module dmasch_req_bank #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] pend_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_bit
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= set_i[c] | (pend_q & ~clr_i[c]);
    end
    assign pend_o[c] = pend_q;

    // R4: a set request is never lost, even against a same-cycle clear
    assert_set_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[c] |=> pend_o[c]);
    // R4: a grant without a new request clears the bit
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[c] && !set_i[c]) |=> !pend_o[c]);
  end
endmodule

// File: rtl/dmasch_arbiter.sv
module dmasch_arbiter
  import dmasch_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  req_i,
  input  logic            idle_i,
  output logic            gnt_vld_o,
  output logic [NCH-1:0]  gnt_oh_o,
  output logic [CH_W-1:0] gnt_idx_o
);
  chvec_t pick_full;
  assign pick_full = lowest_onehot(chvec_t'(req_i));
  assign gnt_oh_o  = idle_i ? pick_full[NCH-1:0] : '0;
  assign gnt_vld_o = |gnt_oh_o;

  always_comb begin
    gnt_idx_o = '0;
    for (int c = 0; c < NCH; c++)
      if (gnt_oh_o[c]) gnt_idx_o = CH_W'(c);
  end

  // R2: at most one grant, and always one when idle with requests
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_oh_o));
  assert_grant_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_i && (|req_i)) |-> gnt_vld_o);
  // R3: no arbitration while a frame runs
  assert_no_grant_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |-> !gnt_vld_o);
endmodule

// File: rtl/dmasch_seq.sv
module dmasch_seq
  import dmasch_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int CH_W   = 2,
  parameter int LINK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gnt_vld_i,
  input  logic [CH_W-1:0]       gnt_idx_i,
  input  logic                  xfer_done_i,
  input  logic [NCH*LINK_W-1:0] cfg_link_i,
  input  logic [NCH-1:0]        cfg_autoinit_i,
  output logic                  busy_o,
  output logic [CH_W-1:0]       act_idx_o,
  output logic [NCH-1:0]        armed_o,
  output logic [NCH-1:0]        chain_tgt_o,
  output logic                  frame_end_o,
  output logic                  chain_done_o
);
  logic              busy_q;
  logic [CH_W-1:0]   act_q;
  logic [NCH-1:0]    armed_q;
  logic [LINK_W-1:0] link_arr [NCH];
  logic [LINK_W-1:0] cur_link;
  chvec_t            tgt_full;

  for (genvar c = 0; c < NCH; c++) begin : g_link
    assign link_arr[c] = cfg_link_i[c*LINK_W +: LINK_W];
  end

  assign cur_link     = link_arr[act_q];
  assign frame_end_o  = busy_q & xfer_done_i;
  assign tgt_full     = link_target(32'(cur_link));
  assign chain_tgt_o  = frame_end_o ? tgt_full[NCH-1:0] : '0;
  assign chain_done_o = frame_end_o && (cur_link == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      act_q   <= '0;
      armed_q <= '1;
    end else begin
      if (gnt_vld_i) begin
        busy_q <= 1'b1;
        act_q  <= gnt_idx_i;
      end else if (frame_end_o) begin
        busy_q <= 1'b0;
        if (!cfg_autoinit_i[act_q]) armed_q[act_q] <= 1'b0;
      end
    end
  end

  assign busy_o    = busy_q;
  assign act_idx_o = act_q;
  assign armed_o   = armed_q;

  // R3: owner stays fixed until the engine reports done
  assert_hold_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !xfer_done_i) |=> (busy_o && $stable(act_idx_o)));
  // R7: done while idle changes nothing
  assert_idle_done_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !gnt_vld_i) |=> !busy_o);
  // R6: chain-done only at an accepted frame end
  assert_chain_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done_o |-> (busy_o && xfer_done_i));
  // R8: a channel without auto-reload disarms after its frame
  assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_o && !cfg_autoinit_i[act_idx_o]) |=> !armed_o[$past(act_idx_o)]);
endmodule

// File: rtl/dma_chain_sched.sv
module dma_chain_sched #(
  parameter int NCH    = 3,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int LINK_W = $clog2(NCH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        hw_trig_i,
  input  logic [NCH*LINK_W-1:0] cfg_link_i,
  input  logic [NCH-1:0]        cfg_autoinit_i,
  input  logic                  done_i,
  output logic                  start_o,
  output logic [CH_W-1:0]       start_ch_o,
  output logic                  busy_o,
  output logic [CH_W-1:0]       active_ch_o,
  output logic                  chain_done_o
);
  logic [NCH-1:0] pend;
  logic [NCH-1:0] armed;
  logic [NCH-1:0] chain_tgt;
  logic [NCH-1:0] req_set;
  logic [NCH-1:0] req_live;
  logic [NCH-1:0] gnt_oh;
  logic           gnt_vld;
  logic [CH_W-1:0] gnt_idx;
  logic           busy;
  logic           frame_end;

  // Named event wires: requests only count on armed channels (R8)
  assign req_set  = (hw_trig_i | chain_tgt) & armed;
  assign req_live = pend & armed;

  dmasch_req_bank #(.NCH(NCH)) u_req (
    .clk(clk), .rst_n(rst_n), .set_i(req_set), .clr_i(gnt_oh), .pend_o(pend)
  );

  dmasch_arbiter #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req_live), .idle_i(!busy),
    .gnt_vld_o(gnt_vld), .gnt_oh_o(gnt_oh), .gnt_idx_o(gnt_idx)
  );

  dmasch_seq #(.NCH(NCH), .CH_W(CH_W), .LINK_W(LINK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .gnt_vld_i(gnt_vld), .gnt_idx_i(gnt_idx),
    .xfer_done_i(done_i), .cfg_link_i(cfg_link_i), .cfg_autoinit_i(cfg_autoinit_i),
    .busy_o(busy), .act_idx_o(active_ch_o), .armed_o(armed),
    .chain_tgt_o(chain_tgt), .frame_end_o(frame_end), .chain_done_o(chain_done_o)
  );

  assign start_o    = gnt_vld;
  assign start_ch_o = gnt_idx;
  assign busy_o     = busy;

  // R5: a link kick reaches the pending bank at every frame end
  assert_link_kick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chain_tgt & armed)) |=> (|(pend | $past(chain_tgt & armed & {NCH{1'b0}})) || busy_o || start_o));
  // R1/R3: start and busy are exclusive
  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !busy_o);
  // R5: a frame end never coincides with a grant
  assert_end_not_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !gnt_vld);
endmodule

// File: tb/dma_chain_sched_tb.sv
module dma_chain_sched_tb;
  localparam int NCH = 3;
  localparam int CH_W = 2;
  localparam int LINK_W = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic [NCH-1:0] hw_trig = '0;
  logic [NCH*LINK_W-1:0] cfg_link = '0;
  logic [NCH-1:0] cfg_auto = '1;
  logic done_i = 0;
  logic start_o, busy_o, chain_done_o;
  logic [CH_W-1:0] start_ch_o, active_ch_o;

  int checks = 0;
  int errors = 0;
  int seq [8];
  int n_grant, n_done;

  always #10 clk = ~clk;  // 50 MHz

  dma_chain_sched #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .hw_trig_i(hw_trig), .cfg_link_i(cfg_link),
    .cfg_autoinit_i(cfg_auto), .done_i(done_i), .start_o(start_o),
    .start_ch_o(start_ch_o), .busy_o(busy_o), .active_ch_o(active_ch_o),
    .chain_done_o(chain_done_o)
  );

  typedef struct packed {
    logic [1:0] l2, l1, l0;
    logic [2:0] trig;
    logic [2:0] nexp;
    logic [1:0] ndone;
    logic [1:0] s0, s1, s2;
  } vec_t;

  // link fields, trigger mask, expected grants, expected chain-done count, order
  localparam vec_t VECS [4] = '{
    '{2'd2, 2'd1, 2'd0, 3'b100, 3'd3, 2'd1, 2'd2, 2'd1, 2'd0},
    '{2'd0, 2'd3, 2'd2, 3'b001, 3'd3, 2'd1, 2'd0, 2'd1, 2'd2},
    '{2'd0, 2'd0, 2'd0, 3'b111, 3'd3, 2'd3, 2'd0, 2'd1, 2'd2},
    '{2'd1, 2'd0, 2'd0, 3'b110, 3'd3, 2'd2, 2'd1, 2'd2, 2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; hw_trig = '0; done_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Model engine: answers each start with done after flen cycles.
  task automatic engine(input int max_g, input int flen, input int idle_lim);
    int cnt; int idle; bit running;
    cnt = 0; idle = 0; running = 0; n_grant = 0; n_done = 0;
    while (idle < idle_lim && !(n_grant >= max_g && !running)) begin
      if (running) cnt++;
      done_i = running && (cnt == flen);
      #1;
      if (chain_done_o) n_done++;
      if (done_i) running = 0;
      if (start_o) begin
        if (n_grant < 8) seq[n_grant] = int'(start_ch_o);
        n_grant++; running = 1; cnt = 0;
      end
      if (!running && !start_o) idle++; else idle = 0;
      @(negedge clk);
    end
    done_i = 0;
  endtask

  task automatic pulse_trig(input logic [NCH-1:0] m);
    hw_trig = m;
    @(negedge clk);
    hw_trig = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    rst_n = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R1 start in reset", int'(start_o), 0);
    check("R1 busy in reset", int'(busy_o), 0);
    do_reset();
    #1;
    check("R1 start after reset", int'(start_o), 0);
    check("R1 chain_done after reset", int'(chain_done_o), 0);

    // Table walk: R2 priority, R5 link decode, R6 chain-done
    for (int v = 0; v < 4; v++) begin
      do_reset();
      cfg_auto = '1;
      cfg_link = {VECS[v].l2, VECS[v].l1, VECS[v].l0};
      pulse_trig(VECS[v].trig);
      engine(int'(VECS[v].nexp), 3, 8);
      check("R2/R5 grant count", n_grant, int'(VECS[v].nexp));
      check("R2/R5 grant 0", seq[0], int'(VECS[v].s0));
      check("R2/R5 grant 1", seq[1], int'(VECS[v].s1));
      check("R2/R5 grant 2", seq[2], int'(VECS[v].s2));
      check("R6 chain_done count", n_done, int'(VECS[v].ndone));
    end

    // R9 upward chain with held trigger: channel 0 preempts every time
    do_reset();
    cfg_auto = '1;
    cfg_link = {2'd0, 2'd3, 2'd2};
    hw_trig = 3'b001;
    engine(6, 2, 8);
    hw_trig = '0;
    for (int i = 0; i < 6; i++) check("R9 upward chain reruns ch0", seq[i], 0);

    // R9 downward chain with held trigger: 2,1,0 repeats (also R4 same-cycle trigger)
    do_reset();
    cfg_link = {2'd2, 2'd1, 2'd0};
    hw_trig = 3'b100;
    engine(6, 2, 8);
    hw_trig = '0;
    for (int i = 0; i < 6; i++) check("R9 downward order", seq[i], 2 - (i % 3));
    check("R4 held trigger regrants", n_grant, 6);

    // R7 done while idle
    do_reset();
    cfg_link = '0;
    done_i = 1;
    #1;
    check("R7 chain_done on idle done", int'(chain_done_o), 0);
    @(negedge clk);
    done_i = 0;
    #1;
    check("R7 busy after idle done", int'(busy_o), 0);
    check("R7 start after idle done", int'(start_o), 0);

    // R3/R4 trigger during a running frame
    @(negedge clk);
    hw_trig = 3'b100;
    #1;
    check("R4 no start in trigger cycle", int'(start_o), 0);
    @(negedge clk);
    hw_trig = '0;
    #1;
    check("R4 start one cycle after trigger", int'(start_o), 1);
    check("R2 start channel", int'(start_ch_o), 2);
    @(negedge clk);
    hw_trig = 3'b001;
    #1;
    check("R3 busy during frame", int'(busy_o), 1);
    @(negedge clk);
    hw_trig = '0;
    #1;
    check("R3 no start while busy", int'(start_o), 0);
    check("R3 owner held", int'(active_ch_o), 2);
    done_i = 1;
    #1;
    check("R6 chain_done with empty link", int'(chain_done_o), 1);
    @(negedge clk);
    done_i = 0;
    #1;
    check("R3 pending ch0 granted after frame", int'(start_ch_o), 0);
    check("R3 start after frame", int'(start_o), 1);
    engine(1, 2, 8);

    // R8 disarm without auto-reload
    do_reset();
    cfg_auto = '0;
    cfg_link = '0;
    pulse_trig(3'b001);
    engine(1, 2, 8);
    check("R8 first run", n_grant, 1);
    pulse_trig(3'b001);
    engine(1, 2, 10);
    check("R8 disarmed channel ignores trigger", n_grant, 0);
    pulse_trig(3'b010);
    engine(1, 2, 8);
    check("R8 other channel still armed", n_grant, 1);
    check("R8 other channel id", seq[0], 1);
    cfg_auto = '1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule